// File: doc/BRIEF.md
# Packed Lane SIMD ALU

This block is a one-cycle vector arithmetic unit for a processor with wide registers. Each issued operation takes two wide source operands, `src_s` and `src_t`, cuts them into independent lanes of 8, 16 or 32 bits, and computes every lane on its own. No carry, borrow or data crosses a lane boundary, so the 64-bit halves of the word are never coupled either. The operations are add and subtract in three forms (wrap-around, signed clamp and unsigned clamp), lane-wise compares that return all-ones or all-zeros masks, and the four bitwise functions AND, OR, XOR and NOR, which ignore lanes.

The issuing stage presents an opcode, a lane-width code, the operands and a destination register index with a one-cycle `in_valid` strobe. On the next clock edge the result is registered and `wr_en` is raised for one cycle so that the register file can take `res_q`. An issue aimed at register index zero, or one that carries an undefined opcode, has no effect: `wr_en` stays low and `res_q` keeps its last value.

Top module: `simd_alu`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it is released, `res_q` is zero and `wr_en` is low.
- R2: An issue with `in_valid` high, a nonzero `dest_idx` and a defined opcode (0 to 11) raises `wr_en` at the next rising clock edge and presents the result on `res_q` in that same cycle. In any cycle that follows no such issue, `wr_en` is low and `res_q` holds its value.
- R3: An issue with `dest_idx` equal to zero leaves `wr_en` low and `res_q` unchanged, whatever the opcode and operands.
- R4: The `lane_sel` code 0 selects 8-bit lanes (16 lanes), 1 selects 16-bit lanes (8 lanes), and 2 or 3 selects 32-bit lanes (4 lanes). Lane k occupies bits k*w to k*w+w-1, and no carry or borrow passes into the next lane.
- R5: Opcode 0 is a lane-wise add and opcode 3 is a lane-wise subtract (`src_s` minus `src_t`), both taken modulo 2^w.
- R6: Opcode 1 (add) and opcode 4 (subtract) clamp each lane, read as a signed value, to the range -2^(w-1) to 2^(w-1)-1.
- R7: Opcode 2 (add) and opcode 5 (subtract) clamp each lane, read as an unsigned value, to the range 0 to 2^w-1.
- R8: Opcodes 6, 7, 8 and 9 compute AND, OR, XOR and NOR of the full operands; `lane_sel` has no effect on their result.
- R9: Opcode 10 sets each lane to all ones when the two source lanes are equal, and to all zeros otherwise.
- R10: Opcode 11 sets each lane to all ones when the `src_s` lane is strictly greater than the `src_t` lane, both read as signed values of the lane width, and to all zeros otherwise.
- R11: Opcodes 12 to 15 are undefined: an issue carrying one leaves `wr_en` low and `res_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Issue strobe for the operation on the other inputs |
| op | input | 4 | Opcode (0 to 11 defined) |
| lane_sel | input | 2 | Lane width code: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| src_s | input | 128 | First source operand |
| src_t | input | 128 | Second source operand |
| dest_idx | input | 5 | Destination register index; zero means no write |
| res_q | output | 128 | Registered result |
| wr_en | output | 1 | One-cycle write strobe for `res_q` |

## Verification
On every cycle the assertions check the write protocol: a strobe follows each qualifying issue, and none follows an idle cycle, a zero destination or an undefined opcode, during which the result holds. They also check that compare results consist of whole-lane masks, that comparing equal operands yields all ones, and that AND reaches the output unchanged one cycle later. Only the bench's scenarios can show the numeric contents of the lanes: where wrap-around ends and clamping begins at each width, that no carry leaks across lane or half boundaries, the signed reading of the greater-than compare, and that the lane code leaves bitwise results alone.

// File: rtl/simd_pkg.sv
package simd_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDS = 4'd1,
        OP_ADDU = 4'd2,
        OP_SUB  = 4'd3,
        OP_SUBS = 4'd4,
        OP_SUBU = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_NOR  = 4'd9,
        OP_CEQ  = 4'd10,
        OP_CGT  = 4'd11
    } simd_op_e;

    localparam int unsigned NUM_WIDTHS = 3;

    function automatic logic op_defined(input logic [3:0] code);
        return code <= 4'd11;
    endfunction

    function automatic logic op_bitwise(input logic [3:0] code);
        return (code >= 4'd6) && (code <= 4'd9);
    endfunction

endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  simd_op_e       op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);

    logic [W:0]   sum;
    logic [W:0]   dif;
    logic         ovf_add_s;
    logic         ovf_sub_s;
    logic [W-1:0] clamp_s;

    always_comb begin
        sum       = {1'b0, a} + {1'b0, b};
        dif       = {1'b0, a} - {1'b0, b};
        ovf_add_s = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
        ovf_sub_s = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
        clamp_s   = a[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        case (op)
            OP_ADD:  y = sum[W-1:0];
            OP_ADDS: y = ovf_add_s ? clamp_s : sum[W-1:0];
            OP_ADDU: y = sum[W] ? {W{1'b1}} : sum[W-1:0];
            OP_SUB:  y = dif[W-1:0];
            OP_SUBS: y = ovf_sub_s ? clamp_s : dif[W-1:0];
            OP_SUBU: y = dif[W] ? {W{1'b0}} : dif[W-1:0];
            OP_CEQ:  y = {W{a == b}};
            OP_CGT:  y = {W{$signed(a) > $signed(b)}};
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank
    import simd_pkg::*;
#(
    parameter int unsigned DATA_W = 128,
    parameter int unsigned LANE_W = 8
) (
    input  simd_op_e          op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    localparam int unsigned NUM_LANES = DATA_W / LANE_W;

    generate
        for (genvar gl = 0; gl < NUM_LANES; gl++) begin : g_lane
            simd_lane_alu #(
                .W (LANE_W)
            ) u_lane (
                .op (op),
                .a  (a[gl*LANE_W +: LANE_W]),
                .b  (b[gl*LANE_W +: LANE_W]),
                .y  (y[gl*LANE_W +: LANE_W])
            );
        end
    endgenerate

endmodule

// File: rtl/simd_bitwise.sv
module simd_bitwise
    import simd_pkg::*;
#(
    parameter int unsigned DATA_W = 128
) (
    input  simd_op_e          op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    always_comb begin
        case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOR:  y = ~(a | b);
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_pkg::*;
#(
    parameter int unsigned DATA_W = 128,
    parameter int unsigned IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic [1:0]        lane_sel,
    input  logic [DATA_W-1:0] src_s,
    input  logic [DATA_W-1:0] src_t,
    input  logic [IDX_W-1:0]  dest_idx,
    output logic [DATA_W-1:0] res_q,
    output logic              wr_en
);

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              we;
    } alu_state_t;

    alu_state_t        st_d;
    alu_state_t        st_q;
    simd_op_e          op_dec;
    logic [DATA_W-1:0] bank_y [NUM_WIDTHS];
    logic [DATA_W-1:0] logic_y;
    logic [DATA_W-1:0] lane_y;

    assign op_dec = simd_op_e'(op);

    generate
        for (genvar gw = 0; gw < NUM_WIDTHS; gw++) begin : g_width
            simd_lane_bank #(
                .DATA_W (DATA_W),
                .LANE_W (8 << gw)
            ) u_bank (
                .op (op_dec),
                .a  (src_s),
                .b  (src_t),
                .y  (bank_y[gw])
            );
        end
    endgenerate

    simd_bitwise #(
        .DATA_W (DATA_W)
    ) u_bitwise (
        .op (op_dec),
        .a  (src_s),
        .b  (src_t),
        .y  (logic_y)
    );

    always_comb begin
        case (lane_sel)
            2'd0:    lane_y = bank_y[0];
            2'd1:    lane_y = bank_y[1];
            default: lane_y = bank_y[2];
        endcase
    end

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (in_valid && (dest_idx != '0) && op_defined(op)) begin
            st_d.we  = 1'b1;
            st_d.res = op_bitwise(op) ? logic_y : lane_y;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_q = st_q.res;
    assign wr_en = st_q.we;

endmodule

// File: rtl/simd_alu_checker.sv
module simd_alu_checker
    import simd_pkg::*;
#(
    parameter int unsigned DATA_W = 128,
    parameter int unsigned IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        op,
    input logic [1:0]        lane_sel,
    input logic [DATA_W-1:0] src_s,
    input logic [DATA_W-1:0] src_t,
    input logic [IDX_W-1:0]  dest_idx,
    input logic [DATA_W-1:0] res_q,
    input logic              wr_en
);

    logic issue_ok;
    logic is_cmp;
    logic mask8_ok;
    logic mask16_ok;
    logic mask32_ok;

    assign issue_ok = in_valid && (dest_idx != '0) && (op <= 4'd11);
    assign is_cmp   = (op == 4'd10) || (op == 4'd11);

    always_comb begin
        mask8_ok  = 1'b1;
        mask16_ok = 1'b1;
        mask32_ok = 1'b1;
        for (int k = 0; k < DATA_W / 8; k++) begin
            if (res_q[k*8 +: 8] != '0 && res_q[k*8 +: 8] != '1) mask8_ok = 1'b0;
        end
        for (int k = 0; k < DATA_W / 16; k++) begin
            if (res_q[k*16 +: 16] != '0 && res_q[k*16 +: 16] != '1) mask16_ok = 1'b0;
        end
        for (int k = 0; k < DATA_W / 32; k++) begin
            if (res_q[k*32 +: 32] != '0 && res_q[k*32 +: 32] != '1) mask32_ok = 1'b0;
        end
    end

    p_write_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ok |=> wr_en);

    p_quiet_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_ok |=> (!wr_en && $stable(res_q)));

    p_dest_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dest_idx == '0) |=> !wr_en);

    p_undef_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > 4'd11) |=> (!wr_en && $stable(res_q)));

    p_and_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ok && op == 4'd6) |=> (res_q == $past(src_s & src_t)));

    p_eq_self_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ok && op == 4'd10 && src_s == src_t) |=> (&res_q));

    p_cmp_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ok && is_cmp) |=>
            (($past(lane_sel) == 2'd0) ? mask8_ok :
             ($past(lane_sel) == 2'd1) ? mask16_ok : mask32_ok));

endmodule

bind simd_alu simd_alu_checker #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
) u_simd_alu_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .op       (op),
    .lane_sel (lane_sel),
    .src_s    (src_s),
    .src_t    (src_t),
    .dest_idx (dest_idx),
    .res_q    (res_q),
    .wr_en    (wr_en)
);

// File: tb/simd_alu_bench.sv
module simd_alu_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [3:0]   op = '0;
    logic [1:0]   lane_sel = '0;
    logic [127:0] src_s = '0;
    logic [127:0] src_t = '0;
    logic [4:0]   dest_idx = '0;
    logic [127:0] res_q;
    logic         wr_en;

    int           n_checks = 0;
    int           n_fails = 0;
    logic [127:0] exp_res = '0;
    logic         exp_we = 1'b0;

    always #4 clk = ~clk;

    simd_alu u_simd_alu (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .op       (op),
        .lane_sel (lane_sel),
        .src_s    (src_s),
        .src_t    (src_t),
        .dest_idx (dest_idx),
        .res_q    (res_q),
        .wr_en    (wr_en)
    );

    function automatic logic [127:0] model(input logic [3:0] code, input logic [1:0] ls,
                                           input logic [127:0] s, input logic [127:0] t);
        int           w;
        longint       full, half, mask, ua, ub, sa, sb, r;
        logic [127:0] acc, ts, tt;
        case (code)
            4'd6: return s & t;
            4'd7: return s | t;
            4'd8: return s ^ t;
            4'd9: return ~(s | t);
            default: ;
        endcase
        w    = (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : 32;
        full = longint'(1) << w;
        half = full / 2;
        mask = full - 1;
        acc  = '0;
        for (int k = 0; k < 128 / w; k++) begin
            ts = s >> (k * w);
            tt = t >> (k * w);
            ua = longint'(ts[31:0]) & mask;
            ub = longint'(tt[31:0]) & mask;
            sa = (ua >= half) ? ua - full : ua;
            sb = (ub >= half) ? ub - full : ub;
            case (code)
                4'd0: r = ua + ub;
                4'd3: r = ua - ub;
                4'd1: begin r = sa + sb; if (r > half - 1) r = half - 1; if (r < -half) r = -half; end
                4'd4: begin r = sa - sb; if (r > half - 1) r = half - 1; if (r < -half) r = -half; end
                4'd2: begin r = ua + ub; if (r > mask) r = mask; end
                4'd5: begin r = ua - ub; if (r < 0) r = 0; end
                4'd10: r = (ua == ub) ? mask : 0;
                4'd11: r = (sa > sb) ? mask : 0;
                default: r = 0;
            endcase
            acc = acc | ((128'(r & mask)) << (k * w));
        end
        return acc;
    endfunction

    function automatic string tag_of(input logic [3:0] code, input logic [4:0] d);
        if (d == 5'd0) return "R3";
        case (code)
            4'd0, 4'd3: return "R5";
            4'd1, 4'd4: return "R6";
            4'd2, 4'd5: return "R7";
            4'd6, 4'd7, 4'd8, 4'd9: return "R8";
            4'd10: return "R9";
            4'd11: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [127:0] act_r, input logic act_w);
        n_checks++;
        if (act_r !== exp_res || act_w !== exp_we) begin
            n_fails++;
            $display("FAIL %s actual res=%h we=%b expected res=%h we=%b",
                     tag, act_r, act_w, exp_res, exp_we);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    endtask

    // Drive at a falling edge, sample one full cycle later, then idle one cycle.
    task automatic issue(input logic [3:0] code, input logic [1:0] ls,
                         input logic [127:0] s, input logic [127:0] t,
                         input logic [4:0] d, input string tag);
        @(negedge clk);
        check("R2 idle", res_q, wr_en);
        in_valid = 1'b1;
        op       = code;
        lane_sel = ls;
        src_s    = s;
        src_t    = t;
        dest_idx = d;
        @(negedge clk);
        if (d != 5'd0 && code <= 4'd11) begin
            exp_res = model(code, ls, s, t);
            exp_we  = 1'b1;
        end else begin
            exp_we  = 1'b0;
        end
        check(tag, res_q, wr_en);
        in_valid = 1'b0;
        exp_we   = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [127:0] rs, rt;
        repeat (3) @(negedge clk);
        check("R1 in reset", res_q, wr_en);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", res_q, wr_en);

        // R5 and R4: carries stop at each lane edge
        issue(4'd0, 2'd0, {16{8'hFF}}, {16{8'h01}}, 5'd1, "R5 add8 R4");
        issue(4'd0, 2'd1, {16{8'hFF}}, {16{8'h01}}, 5'd1, "R5 add16 R4");
        issue(4'd0, 2'd2, {4{32'hFFFF_FFFF}}, {4{32'h0000_0001}}, 5'd2, "R5 add32 R4");
        issue(4'd0, 2'd3, {4{32'hFFFF_FFFF}}, {4{32'h0000_0001}}, 5'd2, "R4 code3 as 32");
        issue(4'd3, 2'd0, {16{8'h00}}, {16{8'h01}}, 5'd3, "R5 sub8 wrap");
        issue(4'd3, 2'd2, {2{64'h0000_0000_8000_0000}}, {2{64'h0000_0001_0000_0001}}, 5'd3, "R5 sub32 R4");
        // R6 signed clamps
        issue(4'd1, 2'd0, {8{16'h7F80}}, {8{16'h0180}}, 5'd4, "R6 adds8");
        issue(4'd4, 2'd0, {8{16'h807F}}, {8{16'h01FF}}, 5'd4, "R6 subs8");
        issue(4'd1, 2'd1, {4{32'h7FFF_8000}}, {4{32'h0001_FFFF}}, 5'd4, "R6 adds16");
        issue(4'd4, 2'd2, {2{64'h8000_0000_7FFF_FFFF}}, {2{64'h0000_0001_FFFF_FFFF}}, 5'd4, "R6 subs32");
        // R7 unsigned clamps
        issue(4'd2, 2'd0, {16{8'hF0}}, {16{8'h20}}, 5'd5, "R7 addu8");
        issue(4'd5, 2'd0, {16{8'h10}}, {16{8'h20}}, 5'd5, "R7 subu8");
        issue(4'd2, 2'd2, {4{32'hFFFF_FFF0}}, {4{32'h0000_000F}}, 5'd5, "R7 addu32 edge");
        issue(4'd5, 2'd1, {8{16'h0005}}, {8{16'h0005}}, 5'd5, "R7 subu16 zero");
        // R8 bitwise; lane code ignored
        rs = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        rt = 128'hFFFF_0000_F0F0_0F0F_AAAA_5555_0000_FFFF;
        issue(4'd6, 2'd0, rs, rt, 5'd6, "R8 and");
        issue(4'd6, 2'd2, rs, rt, 5'd6, "R8 and lane code");
        issue(4'd7, 2'd1, rs, rt, 5'd6, "R8 or");
        issue(4'd8, 2'd3, rs, rt, 5'd6, "R8 xor");
        issue(4'd9, 2'd0, rs, rt, 5'd6, "R8 nor");
        // R9 and R10 compares
        issue(4'd10, 2'd0, rs, {rs[127:64], ~rs[63:0]}, 5'd7, "R9 eq8");
        issue(4'd10, 2'd1, rs, rs, 5'd7, "R9 eq16 self");
        issue(4'd11, 2'd0, {8{16'h807F}}, {8{16'h7F80}}, 5'd8, "R10 gt8 signed");
        issue(4'd11, 2'd1, {8{16'h1234}}, {8{16'h1234}}, 5'd8, "R10 gt16 equal");
        issue(4'd11, 2'd2, {2{64'hFFFF_FFFF_0000_0001}}, {2{64'h8000_0000_0000_0000}}, 5'd8, "R10 gt32");
        // R3 destination zero: result holds
        issue(4'd0, 2'd0, {16{8'h11}}, {16{8'h22}}, 5'd9, "R5 before R3");
        issue(4'd8, 2'd0, rs, rt, 5'd0, "R3 dest zero xor");
        issue(4'd1, 2'd1, rt, rs, 5'd0, "R3 dest zero adds");
        // R11 undefined opcodes
        issue(4'd12, 2'd0, rs, rt, 5'd10, "R11 op12");
        issue(4'd15, 2'd2, rt, rs, 5'd31, "R11 op15");

        for (int i = 0; i < 300; i++) begin
            logic [3:0]  c;
            logic [4:0]  d;
            c  = 4'($urandom % 14);
            d  = ((i % 7) == 0) ? 5'd0 : 5'($urandom % 31 + 1);
            rs = {$urandom, $urandom, $urandom, $urandom};
            rt = (i % 5 == 0) ? rs : {$urandom, $urandom, $urandom, $urandom};
            issue(c, 2'($urandom % 4), rs, rt, d, tag_of(c, d));
        end

        @(negedge clk);
        check("R2 final idle", res_q, wr_en);
        summary();
        $finish;
    end

endmodule